// File: doc/BRIEF.md
# Double-Precision to Unsigned 64-bit Integer Converter

This block turns a binary64 floating-point operand into an unsigned 64-bit integer under one of four rounding directions. The result comes with an invalid flag and an inexact flag. Operands arrive on a valid/ready handshake, one per cycle. Results leave two cycles later on a matching valid/ready pair. A low `out_ready` freezes the whole pipeline.

The first stage splits the operand into sign, biased exponent and fraction. It restores the implicit leading one and classifies the special cases. It then places the significand in a 128-bit fixed-point value: an integer word, and a fraction word whose least significant bit collects every bit shifted beyond it. The second stage rounds the integer word in the selected direction, saturates or rejects out-of-range values and produces the flags.

Values below zero need care because the target type has no negative range. A negative value whose magnitude rounds to zero yields zero with no flag at all. Any other negative value, including negative infinity, yields zero and raises invalid. A NaN of either sign saturates to all ones.

Top module: `dbl2u64_conv`

## Requirements
- R1: A positive in-range value whose magnitude is an exact integer converts to that integer with both flags low. This includes 2^52 (no alignment shift), 2^63 and the largest double below 2^64.
- R2: The `in_rmode` encoding is 00 nearest-even, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity. A positive value with a fractional part rounds in that direction and raises inexact only.
- R3: In nearest-even mode, a fraction above one half rounds up and a fraction below one half rounds down. An exact half rounds to the even integer.
- R4: Significand bits shifted below the 64-bit fraction word are kept as a sticky bit. A tiny positive normal value therefore raises inexact, and it rounds to 1 toward plus infinity.
- R5: A positive value of 2^64 or more, or plus infinity, returns all ones with invalid set and inexact clear.
- R6: A NaN of either sign returns all ones with invalid set.
- R7: A negative value of magnitude one or more, or minus infinity, returns zero with invalid set.
- R8: A negative value of magnitude below one returns zero. It raises invalid when the magnitude rounds to a nonzero integer, and no flag when it rounds to zero. Negative zero gives zero with no flag. Invalid and inexact are never both set.
- R9: With `in_ftz` high, a subnormal operand (exponent field zero) converts as zero with no flag. Normal operands are unaffected.
- R10: An operand accepted at one rising edge appears with `out_valid` high after the second rising edge, provided `out_ready` is high. Back-to-back operands give back-to-back results.
- R11: While `out_valid` is high and `out_ready` is low, the output holds its value and `in_ready` is low.
- R12: During and after reset, `out_valid` is low and `in_ready` is high until an operand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_op | input | OP_W (64) | binary64 operand |
| in_rmode | input | 2 | Rounding direction (see R2) |
| in_ftz | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | OUT_W (64) | Unsigned integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The bench builds the block with its default widths: an 11-bit exponent, a 52-bit fraction and a 64-bit result. This places the saturation boundary at biased exponent 0x43E and the no-shift point at 0x433, so 2^63, 2^64 and 2^52 can be hit directly. With these widths, right shifts of over a thousand places push a normal operand entirely into the sticky bit, which exercises the jamming path. The 11-bit exponent also gives true NaN and infinity encodings of both signs for the special-case ordering.

// File: rtl/dbl2u_pkg.sv
package dbl2u_pkg;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_ZERO   = 2'b01,
      RM_TO_POS    = 2'b10,
      RM_TO_NEG    = 2'b11
   } rmode_e;

   // Operand classification carried from the align stage to the round stage
   typedef struct packed {
      logic is_nan;    // any NaN, either sign
      logic neg_big;   // negative, magnitude >= 1 (includes -inf)
      logic too_big;   // positive, magnitude >= 2^OUT_W (includes +inf)
      logic sign;
   } cls_t;

endpackage

// File: rtl/d2u_unpack.sv
module d2u_unpack
   import dbl2u_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int OUT_W  = 64
) (
   input  logic [EXP_W+FRAC_W:0] op,
   input  logic                  ftz,
   output logic [FRAC_W:0]       sig,
   output logic [EXP_W-1:0]      exp_b,
   output cls_t                  cls
);
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int OVF_EXP = BIAS + OUT_W - 1;

   logic              sign_b;
   logic [FRAC_W-1:0] frac_b;
   logic              subnormal;
   logic              exp_ones;

   assign sign_b    = op[EXP_W+FRAC_W];
   assign exp_b     = op[FRAC_W +: EXP_W];
   assign frac_b    = op[FRAC_W-1:0];
   assign subnormal = (exp_b == '0);
   assign exp_ones  = &exp_b;

   // Hidden one restored for normal values; flushed subnormals become zero
   always_comb begin
      if (subnormal && ftz) sig = '0;
      else                  sig = {!subnormal, frac_b};
   end

   always_comb begin
      cls.sign    = sign_b;
      cls.is_nan  = exp_ones && (frac_b != '0);
      cls.neg_big = sign_b && !cls.is_nan && (exp_b > EXP_W'(BIAS - 1));
      cls.too_big = !sign_b && !cls.is_nan && (exp_b > EXP_W'(OVF_EXP));
   end

endmodule

// File: rtl/d2u_align.sv
module d2u_align #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int OUT_W  = 64
) (
   input  logic [FRAC_W:0]  sig,
   input  logic [EXP_W-1:0] exp_b,
   output logic [OUT_W-1:0] int_w,
   output logic [OUT_W-1:0] frac_w
);
   localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
   localparam int PIVOT = BIAS + FRAC_W;   // exponent needing no shift
   localparam int WIDE  = 2 * OUT_W;
   localparam int SH_W  = EXP_W + 2;
   localparam int PAD_W = OUT_W - FRAC_W - 1;

   logic signed [SH_W-1:0] shamt;
   logic        [SH_W-1:0] lamt;
   logic        [SH_W-1:0] ramt;
   logic        [WIDE-1:0] wide_in;
   logic        [WIDE-1:0] shifted;
   logic        [WIDE-1:0] lost_mask;
   logic                   lost;
   logic        [OUT_W-1:0] sig_ext;

   assign shamt   = $signed(SH_W'(PIVOT)) - $signed({2'b00, exp_b});
   assign lamt    = SH_W'(-shamt);
   assign ramt    = SH_W'(shamt);
   assign sig_ext = {{PAD_W{1'b0}}, sig};
   assign wide_in = {sig_ext, {OUT_W{1'b0}}};

   always_comb begin
      shifted   = '0;
      lost_mask = '0;
      lost      = 1'b0;
      if (shamt <= 0) begin
         int_w  = sig_ext << lamt;
         frac_w = '0;
      end else if (ramt >= SH_W'(WIDE)) begin
         // every significand bit lands below the fraction word
         int_w  = '0;
         frac_w = {{(OUT_W-1){1'b0}}, (sig != '0)};
      end else begin
         shifted   = wide_in >> ramt;
         lost_mask = ~({WIDE{1'b1}} << ramt);
         lost      = |(wide_in & lost_mask);
         int_w     = shifted[WIDE-1:OUT_W];
         frac_w    = shifted[OUT_W-1:0] | {{(OUT_W-1){1'b0}}, lost};
      end
   end

endmodule

// File: rtl/d2u_round.sv
module d2u_round
   import dbl2u_pkg::*;
#(
   parameter int OUT_W = 64
) (
   input  logic [OUT_W-1:0] int_w,
   input  logic [OUT_W-1:0] frac_w,
   input  cls_t             cls,
   input  rmode_e           rmode,
   output logic [OUT_W-1:0] result,
   output logic             invalid,
   output logic             inexact
);
   logic           half;
   logic           below;
   logic           nz;
   logic           inc;
   logic [OUT_W:0] sum;

   assign half  = frac_w[OUT_W-1];
   assign below = |frac_w[OUT_W-2:0];
   assign nz    = half | below;

   always_comb begin
      unique case (rmode)
         RM_NEAR_EVEN: inc = half & (below | int_w[0]);
         RM_TO_ZERO:   inc = 1'b0;
         RM_TO_POS:    inc = !cls.sign & nz;
         RM_TO_NEG:    inc = cls.sign & nz;
         default:      inc = 1'b0;
      endcase
   end

   assign sum = {1'b0, int_w} + (OUT_W+1)'(inc);

   always_comb begin
      result  = '0;
      invalid = 1'b0;
      inexact = 1'b0;
      if (cls.is_nan) begin
         result  = '1;
         invalid = 1'b1;
      end else if (cls.neg_big) begin
         invalid = 1'b1;
      end else if (cls.too_big) begin
         result  = '1;
         invalid = 1'b1;
      end else if (cls.sign) begin
         // below one in magnitude: zero with no flag, or reject
         invalid = (sum != '0);
      end else if (sum[OUT_W]) begin
         result  = '1;
         invalid = 1'b1;
      end else begin
         result  = sum[OUT_W-1:0];
         inexact = nz;
      end
   end

endmodule

// File: rtl/dbl2u64_conv.sv
module dbl2u64_conv
   import dbl2u_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int OUT_W  = 64,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [OP_W-1:0]  in_op,
   input  logic [1:0]       in_rmode,
   input  logic             in_ftz,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [OUT_W-1:0] out_result,
   output logic             out_invalid,
   output logic             out_inexact
);
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int EXP_MAX = (1 << EXP_W) - 1;

   generate
      if (EXP_W < 3) begin : g_bad_exp
         $error("EXP_W too small");
      end
      if (OUT_W <= FRAC_W + 1) begin : g_bad_out
         $error("OUT_W must exceed the significand width");
      end
      if (BIAS + OUT_W - 1 >= EXP_MAX) begin : g_bad_range
         $error("format range cannot reach 2^OUT_W");
      end
   endgenerate

   logic advance;
   assign advance  = !out_valid || out_ready;
   assign in_ready = advance;

   // ---- stage 1: decode and align ----
   logic [FRAC_W:0]  a_sig;
   logic [EXP_W-1:0] a_exp;
   cls_t             a_cls;
   logic [OUT_W-1:0] a_int;
   logic [OUT_W-1:0] a_frac;

   d2u_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_unpack (
      .op    (in_op),
      .ftz   (in_ftz),
      .sig   (a_sig),
      .exp_b (a_exp),
      .cls   (a_cls)
   );

   d2u_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_align (
      .sig    (a_sig),
      .exp_b  (a_exp),
      .int_w  (a_int),
      .frac_w (a_frac)
   );

   logic             s1_valid;
   logic [OUT_W-1:0] s1_int;
   logic [OUT_W-1:0] s1_frac;
   cls_t             s1_cls;
   rmode_e           s1_rm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_int   <= '0;
         s1_frac  <= '0;
         s1_cls   <= '0;
         s1_rm    <= RM_NEAR_EVEN;
      end else if (advance) begin
         s1_valid <= in_valid;
         s1_int   <= a_int;
         s1_frac  <= a_frac;
         s1_cls   <= a_cls;
         s1_rm    <= rmode_e'(in_rmode);
      end
   end

   // ---- stage 2: round, saturate, flag ----
   logic [OUT_W-1:0] r_res;
   logic             r_inv;
   logic             r_inx;

   d2u_round #(.OUT_W(OUT_W)) u_round (
      .int_w   (s1_int),
      .frac_w  (s1_frac),
      .cls     (s1_cls),
      .rmode   (s1_rm),
      .result  (r_res),
      .invalid (r_inv),
      .inexact (r_inx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_invalid <= 1'b0;
         out_inexact <= 1'b0;
      end else if (advance) begin
         out_valid   <= s1_valid;
         out_result  <= r_res;
         out_invalid <= r_inv;
         out_inexact <= r_inx;
      end
   end

endmodule

// File: rtl/d2u_checker.sv
module d2u_checker #(
   parameter int OUT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [OUT_W-1:0] out_result,
   input logic             out_invalid,
   input logic             out_inexact
);

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_invalid && out_inexact)); // R8

   AST_INVALID_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> (out_result == '0 || out_result == '1)); // R5

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                     && $stable(out_invalid) && $stable(out_inexact))); // R11

   AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready); // R11

   AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) ##1 out_ready |=> out_valid); // R10

endmodule

bind dbl2u64_conv d2u_checker #(.OUT_W(OUT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_result  (out_result),
   .out_invalid (out_invalid),
   .out_inexact (out_inexact)
);

// File: tb/tb_dbl2u64_conv.sv
`timescale 1ns/1ps
module tb_dbl2u64_conv;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] in_op = '0;
   logic [1:0]  in_rmode = 2'b00;
   logic        in_ftz = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] out_result;
   logic        out_invalid;
   logic        out_inexact;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dbl2u64_conv dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_rmode(in_rmode), .in_ftz(in_ftz),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact)
   );

   typedef struct packed {
      logic [63:0] op;
      logic [1:0]  rm;
      logic        ftz;
      logic [63:0] res;
      logic        inv;
      logic        inx;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 38;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam vec_t VEC [NV] = '{
      // R1 exact integers
      '{64'h3FF0_0000_0000_0000, 2'd0, 1'b0, 64'd1, 1'b0, 1'b0, 8'd1},
      '{64'h4330_0000_0000_0000, 2'd0, 1'b0, 64'h0010_0000_0000_0000, 1'b0, 1'b0, 8'd1},
      '{64'h4330_0000_0000_0001, 2'd0, 1'b0, 64'h0010_0000_0000_0001, 1'b0, 1'b0, 8'd1},
      '{64'h43E0_0000_0000_0000, 2'd0, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 8'd1},
      '{64'h43EF_FFFF_FFFF_FFFF, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_F800, 1'b0, 1'b0, 8'd1},
      // R3 nearest-even
      '{64'h3FF8_0000_0000_0000, 2'd0, 1'b0, 64'd2, 1'b0, 1'b1, 8'd3},
      '{64'h4004_0000_0000_0000, 2'd0, 1'b0, 64'd2, 1'b0, 1'b1, 8'd3},
      '{64'h3FE0_0000_0000_0000, 2'd0, 1'b0, 64'd0, 1'b0, 1'b1, 8'd3},
      '{64'h4004_0000_0000_0001, 2'd0, 1'b0, 64'd3, 1'b0, 1'b1, 8'd3},
      '{64'h432F_FFFF_FFFF_FFFF, 2'd0, 1'b0, 64'h0010_0000_0000_0000, 1'b0, 1'b1, 8'd3},
      '{64'h3FE0_0000_0000_0001, 2'd0, 1'b0, 64'd1, 1'b0, 1'b1, 8'd3},
      // R2 directed modes
      '{64'h3FF8_0000_0000_0000, 2'd1, 1'b0, 64'd1, 1'b0, 1'b1, 8'd2},
      '{64'h3FF8_0000_0000_0000, 2'd2, 1'b0, 64'd2, 1'b0, 1'b1, 8'd2},
      '{64'h3FF8_0000_0000_0000, 2'd3, 1'b0, 64'd1, 1'b0, 1'b1, 8'd2},
      '{64'h3FE0_0000_0000_0000, 2'd2, 1'b0, 64'd1, 1'b0, 1'b1, 8'd2},
      '{64'h432F_FFFF_FFFF_FFFF, 2'd1, 1'b0, 64'h000F_FFFF_FFFF_FFFF, 1'b0, 1'b1, 8'd2},
      // R4 sticky bits
      '{64'h0010_0000_0000_0000, 2'd2, 1'b0, 64'd1, 1'b0, 1'b1, 8'd4},
      '{64'h0010_0000_0000_0000, 2'd1, 1'b0, 64'd0, 1'b0, 1'b1, 8'd4},
      '{64'h0010_0000_0000_0000, 2'd0, 1'b0, 64'd0, 1'b0, 1'b1, 8'd4},
      '{64'h0000_0000_0000_0001, 2'd2, 1'b0, 64'd1, 1'b0, 1'b1, 8'd4},
      // R5 positive overflow
      '{64'h43F0_0000_0000_0000, 2'd0, 1'b0, ONES, 1'b1, 1'b0, 8'd5},
      '{64'h7FF0_0000_0000_0000, 2'd1, 1'b0, ONES, 1'b1, 1'b0, 8'd5},
      // R6 NaN
      '{64'h7FF8_0000_0000_0000, 2'd0, 1'b0, ONES, 1'b1, 1'b0, 8'd6},
      '{64'hFFF8_0000_0000_0000, 2'd0, 1'b0, ONES, 1'b1, 1'b0, 8'd6},
      '{64'hFFF0_0000_0000_0001, 2'd3, 1'b0, ONES, 1'b1, 1'b0, 8'd6},
      // R7 negative magnitude >= 1
      '{64'hBFF0_0000_0000_0000, 2'd0, 1'b0, 64'd0, 1'b1, 1'b0, 8'd7},
      '{64'hFFF0_0000_0000_0000, 2'd0, 1'b0, 64'd0, 1'b1, 1'b0, 8'd7},
      '{64'hC3F0_0000_0000_0000, 2'd1, 1'b0, 64'd0, 1'b1, 1'b0, 8'd7},
      // R8 small negatives
      '{64'hBFE0_0000_0000_0000, 2'd0, 1'b0, 64'd0, 1'b0, 1'b0, 8'd8},
      '{64'hBFE0_0000_0000_0000, 2'd3, 1'b0, 64'd0, 1'b1, 1'b0, 8'd8},
      '{64'hBFE8_0000_0000_0000, 2'd0, 1'b0, 64'd0, 1'b1, 1'b0, 8'd8},
      '{64'hBFE8_0000_0000_0000, 2'd1, 1'b0, 64'd0, 1'b0, 1'b0, 8'd8},
      '{64'h8000_0000_0000_0000, 2'd3, 1'b0, 64'd0, 1'b0, 1'b0, 8'd8},
      '{64'h8000_0000_0000_0001, 2'd3, 1'b0, 64'd0, 1'b1, 1'b0, 8'd8},
      // R9 flush subnormals
      '{64'h0000_0000_0000_0001, 2'd2, 1'b1, 64'd0, 1'b0, 1'b0, 8'd9},
      '{64'h8000_0000_0000_0001, 2'd3, 1'b1, 64'd0, 1'b0, 1'b0, 8'd9},
      '{64'h000F_FFFF_FFFF_FFFF, 2'd2, 1'b1, 64'd0, 1'b0, 1'b0, 8'd9},
      '{64'h0010_0000_0000_0000, 2'd2, 1'b1, 64'd1, 1'b0, 1'b1, 8'd9}
   };

   task automatic check_out(input string tag, input logic [63:0] res,
                            input logic inv, input logic inx);
      checks++;
      if (out_valid !== 1'b1 || out_result !== res ||
          out_invalid !== inv || out_inexact !== inx) begin
         errors++;
         $display("FAIL %s: got v=%b res=%h inv=%b inx=%b, expected v=1 res=%h inv=%b inx=%b",
                  tag, out_valid, out_result, out_invalid, out_inexact, res, inv, inx);
      end
   endtask

   task automatic check_bit(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [63:0] op, input logic [1:0] rm, input logic ftz);
      in_valid = 1'b1;
      in_op    = op;
      in_rmode = rm;
      in_ftz   = ftz;
   endtask

   initial begin
      // R12 reset state
      #1;
      check_bit("R12 out_valid in reset", out_valid, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R12 out_valid after reset", out_valid, 1'b0);
      check_bit("R12 in_ready after reset", in_ready, 1'b1);

      // table walk: one operand at a time, sampled after the second edge
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].op, VEC[i].rm, VEC[i].ftz);
         @(negedge clk);
         in_valid = 1'b0;
         @(negedge clk);
         check_out($sformatf("R%0d vec %0d op=%h rm=%0d", VEC[i].req, i, VEC[i].op, VEC[i].rm),
                   VEC[i].res, VEC[i].inv, VEC[i].inx);
      end

      // R10 back-to-back stream
      drive(64'h3FF0_0000_0000_0000, 2'd0, 1'b0);
      @(negedge clk);
      drive(64'h4008_0000_0000_0000, 2'd0, 1'b0);
      @(negedge clk);
      drive(64'h4330_0000_0000_0001, 2'd0, 1'b0);
      check_out("R10 stream first", 64'd1, 1'b0, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      check_out("R10 stream second", 64'd3, 1'b0, 1'b0);
      @(negedge clk);
      check_out("R10 stream third", 64'h0010_0000_0000_0001, 1'b0, 1'b0);
      @(negedge clk);
      check_bit("R10 stream drains", out_valid, 1'b0);

      // R11 stall holds output and blocks input
      drive(64'h3FF8_0000_0000_0000, 2'd1, 1'b0);
      @(negedge clk);
      drive(64'hBFF0_0000_0000_0000, 2'd0, 1'b0);
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b0;
      check_out("R11 before stall", 64'd1, 1'b0, 1'b1);
      @(negedge clk);
      check_out("R11 held during stall", 64'd1, 1'b0, 1'b1);
      check_bit("R11 in_ready low in stall", in_ready, 1'b0);
      @(negedge clk);
      check_out("R11 still held", 64'd1, 1'b0, 1'b1);
      out_ready = 1'b1;
      @(negedge clk);
      check_out("R11 after release R7", 64'd0, 1'b1, 1'b0);
      @(negedge clk);
      check_bit("R11 drains", out_valid, 1'b0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule